// File: doc/BRIEF.md
# Private Cache Line Coherence Controller with Silent Prefetch Fill

This block holds the coherence state of a small, directly indexed set of lines in a private first-level cache. One command per cycle arrives on a single operation port and names a line. The command is one of: core load, prefetch, fill data from the shared level, eviction, local store or external downgrade. The block keeps stable states I, S, E, O and M. It also keeps two transient states: one for a demand miss in flight and one for a prefetch in flight.

A load that misses sends one fetch request downstream. The line then waits in the demand transient state. When data returns, the line settles to E or S and the core is told the load is complete. A prefetch takes the same fetch path through its own transient state, and its fill installs the line without telling the core. If a demand load arrives while a prefetch is still in flight for that line, it joins the prefetch instead of sending a second request, and the core is told when the shared fill returns. Evicting a dirty line (M or O) raises a writeback request.

All outputs are registered and respond in the cycle after the command. A combinational probe port reads the state of any line.

Top module: `l1_line_ctrl`

## Requirements
- R1: After reset, every line reads state 0 on the probe port. The encoding is I=0, S=1, E=2, O=3, M=4, demand pending (IS)=5, prefetch pending (P)=6. No output pulse is raised.
- R2: A load (op=1) on a line in I moves it to IS. In the next cycle it raises req_valid for one cycle with req_pf=0 and req_idx equal to the line.
- R3: Fill data (op=3) on a line in IS moves it to E when excl=1 and to S when excl=0. In the next cycle it raises done_valid for one cycle with done_idx equal to the line.
- R4: A prefetch (op=2) on a line in I moves it to P. In the next cycle it raises req_valid for one cycle with req_pf=1.
- R5: Fill data (op=3) on a line in P moves it to E or S by the excl rule of R3, and done_valid stays low.
- R6: A prefetch (op=2) on a line in any state other than I leaves the state unchanged and raises no request.
- R7: A load (op=1) on a line in P moves it to IS and raises no new request. The later fill then raises done_valid.
- R8: A load (op=1) on a line in S, E, O or M leaves the state unchanged and raises done_valid in the next cycle, with no request.
- R9: An eviction (op=4) of a line in S, E, O or M returns it to I. Only when the line was O or M does wb_valid pulse, with wb_idx equal to the line.
- R10: A store (op=5) moves a line in E or M to M. In any other state the store leaves the line unchanged.
- R11: A downgrade (op=6) moves M to O and E to S. Other states are unchanged.
- R12: Fill data on a line in I or in a stable state, and an eviction of a line in I, IS or P, change no state and raise no pulse.
- R13: A load (op=1) on a line already in IS raises no second request and leaves the line in IS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Command: 0 none, 1 load, 2 prefetch, 3 fill, 4 evict, 5 store, 6 downgrade |
| idx | input | IW | Line addressed by the command |
| excl | input | 1 | Fill carries exclusive permission |
| probe_idx | input | IW | Line whose state is read out |
| probe_state | output | 3 | State of the probed line |
| req_valid | output | 1 | Fetch request pulse to the shared level |
| req_idx | output | IW | Line of the fetch request |
| req_pf | output | 1 | Fetch request comes from a prefetch |
| done_valid | output | 1 | Load completion pulse to the core |
| done_idx | output | IW | Line of the completed load |
| wb_valid | output | 1 | Writeback request pulse |
| wb_idx | output | IW | Line to write back |

## Verification
The bench targets the prefetch-then-load merge:
- A design that forgot the merge would send a duplicate request.
- A design that never recorded the demand would leave the core waiting forever.

It fills a pure prefetch and expects silence; a design that reused the demand path would wake the core for data it never asked for. It repeats a prefetch or a load against a line that is already pending or valid; a design that checked only the transient state, or only the valid state, would issue a spurious fetch. It evicts clean, dirty and pending lines, which catches a writeback raised for E or S and a pending line being dropped to I while its fill is still outstanding.

// File: rtl/l1_line_ctrl.sv
module l1_line_ctrl #(
  parameter int NLINES = 8,
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op,
  input  logic [IW-1:0] idx,
  input  logic          excl,
  input  logic [IW-1:0] probe_idx,
  output logic [2:0]    probe_state,
  output logic          req_valid,
  output logic [IW-1:0] req_idx,
  output logic          req_pf,
  output logic          done_valid,
  output logic [IW-1:0] done_idx,
  output logic          wb_valid,
  output logic [IW-1:0] wb_idx
);
  localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3,
                         ST_M = 3'd4, ST_IS = 3'd5, ST_P = 3'd6;
  localparam logic [2:0] OP_LD = 3'd1, OP_PF = 3'd2, OP_FILL = 3'd3,
                         OP_EV = 3'd4, OP_ST = 3'd5, OP_DG = 3'd6;

  logic [2:0] line_st [NLINES];
  logic [2:0] cur, nxt;
  logic       go_req, go_pf, go_done, go_wb, stable;

  assign cur         = line_st[idx];
  assign probe_state = line_st[probe_idx];
  assign stable      = (cur != ST_I) && (cur != ST_IS) && (cur != ST_P);

  always_comb begin
    nxt     = cur;
    go_req  = 1'b0;
    go_pf   = 1'b0;
    go_done = 1'b0;
    go_wb   = 1'b0;
    case (op)
      OP_LD: begin
        if (cur == ST_I) begin
          nxt    = ST_IS;
          go_req = 1'b1;
        end else if (cur == ST_P) begin
          nxt = ST_IS;
        end else if (stable) begin
          go_done = 1'b1;
        end
      end
      OP_PF: begin
        if (cur == ST_I) begin
          nxt    = ST_P;
          go_req = 1'b1;
          go_pf  = 1'b1;
        end
      end
      OP_FILL: begin
        if (cur == ST_IS || cur == ST_P) begin
          nxt     = excl ? ST_E : ST_S;
          go_done = (cur == ST_IS);
        end
      end
      OP_EV: begin
        if (stable) begin
          nxt   = ST_I;
          go_wb = (cur == ST_M) || (cur == ST_O);
        end
      end
      OP_ST: begin
        if (cur == ST_E || cur == ST_M) nxt = ST_M;
      end
      OP_DG: begin
        if (cur == ST_M) nxt = ST_O;
        else if (cur == ST_E) nxt = ST_S;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) line_st[i] <= ST_I;
      req_valid  <= 1'b0;
      req_pf     <= 1'b0;
      done_valid <= 1'b0;
      wb_valid   <= 1'b0;
      req_idx    <= '0;
      done_idx   <= '0;
      wb_idx     <= '0;
    end else begin
      line_st[idx] <= nxt;
      req_valid    <= go_req;
      req_pf       <= go_pf;
      done_valid   <= go_done;
      wb_valid     <= go_wb;
      req_idx      <= idx;
      done_idx     <= idx;
      wb_idx       <= idx;
    end
  end
endmodule

// File: rtl/l1_line_ctrl_chk.sv
module l1_line_ctrl_chk #(
  parameter int NLINES = 8,
  localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op,
  input logic [IW-1:0] idx,
  input logic          req_valid,
  input logic          req_pf,
  input logic          done_valid,
  input logic          wb_valid,
  input logic [IW-1:0] wb_idx,
  input logic [2:0]    line_st [NLINES]
);
  a_r2_req_source: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($past(op) == 3'd1 || $past(op) == 3'd2));

  a_r4_req_pf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_pf == ($past(op) == 3'd2)));

  a_r9_wb_source: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ($past(op) == 3'd4 && $past(idx) == wb_idx));

  a_r12_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_valid, done_valid, wb_valid}));

  a_r6_pf_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd2 && line_st[idx] != 3'd0) |=> !req_valid);

  a_r10_store_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd5 && line_st[idx] == 3'd2) |=> (line_st[$past(idx)] == 3'd4));

  a_r13_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1 && (line_st[idx] == 3'd5 || line_st[idx] == 3'd6)) |=> !req_valid);
endmodule

bind l1_line_ctrl l1_line_ctrl_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .idx(idx),
  .req_valid(req_valid), .req_pf(req_pf), .done_valid(done_valid),
  .wb_valid(wb_valid), .wb_idx(wb_idx), .line_st(line_st)
);

// File: tb/l1_line_ctrl_test.sv
module l1_line_ctrl_test;
  localparam int NL = 8;
  localparam int IW = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [IW-1:0] idx = '0;
  logic excl = 1'b0;
  logic [IW-1:0] probe_idx = '0;
  logic [2:0] probe_state;
  logic req_valid, req_pf, done_valid, wb_valid;
  logic [IW-1:0] req_idx, done_idx, wb_idx;

  always #4 clk = ~clk;

  l1_line_ctrl #(.NLINES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .op(op), .idx(idx), .excl(excl),
    .probe_idx(probe_idx), .probe_state(probe_state),
    .req_valid(req_valid), .req_idx(req_idx), .req_pf(req_pf),
    .done_valid(done_valid), .done_idx(done_idx),
    .wb_valid(wb_valid), .wb_idx(wb_idx)
  );

  typedef struct packed {
    logic       rq;
    logic       pf;
    logic       dn;
    logic       wb;
    logic [IW-1:0] ln;
    logic [2:0] st;
  } exp_t;

  exp_t exp_q[$];
  string tag_q[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int model [NL];

  task automatic apply(input logic [2:0] o, input int ln, input logic x, input string tag);
    exp_t e;
    int s;
    s = model[ln];
    e = '0;
    e.ln = IW'(ln);
    case (o)
      3'd1: if (s == 0) begin s = 5; e.rq = 1; end
            else if (s == 6) s = 5;
            else if (s >= 1 && s <= 4) e.dn = 1;
      3'd2: if (s == 0) begin s = 6; e.rq = 1; e.pf = 1; end
      3'd3: if (s == 5 || s == 6) begin e.dn = (s == 5); s = x ? 2 : 1; end
      3'd4: if (s >= 1 && s <= 4) begin e.wb = (s == 3 || s == 4); s = 0; end
      3'd5: if (s == 2 || s == 4) s = 4;
      3'd6: if (s == 4) s = 3; else if (s == 2) s = 1;
      default: ;
    endcase
    model[ln] = s;
    e.st = 3'(s);
    @(negedge clk);
    op = o; idx = IW'(ln); excl = x; probe_idx = IW'(ln);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        logic bad;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        bad = (req_valid !== e.rq) || (done_valid !== e.dn) || (wb_valid !== e.wb)
           || (probe_state !== e.st)
           || (e.rq && (req_pf !== e.pf || req_idx !== e.ln))
           || (e.dn && done_idx !== e.ln)
           || (e.wb && wb_idx !== e.ln);
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL %s line %0d: got rq=%b pf=%b dn=%b wb=%b st=%0d ri=%0d di=%0d wi=%0d, expected rq=%b pf=%b dn=%b wb=%b st=%0d",
                   t, e.ln, req_valid, req_pf, done_valid, wb_valid, probe_state,
                   req_idx, done_idx, wb_idx, e.rq, e.pf, e.dn, e.wb, e.st);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state of every line and idle outputs
    for (int i = 0; i < NL; i++) begin
      probe_idx = IW'(i);
      #1;
      checks++;
      if (probe_state !== 3'd0 || req_valid !== 1'b0 || done_valid !== 1'b0 || wb_valid !== 1'b0) begin
        fails++;
        $display("FAIL R1 line %0d: got st=%0d rq=%b dn=%b wb=%b, expected st=0 no pulses",
                 i, probe_state, req_valid, done_valid, wb_valid);
      end
    end

    apply(3'd1, 0, 0, "R2 load miss");
    apply(3'd1, 0, 0, "R13 load on pending");
    apply(3'd3, 0, 1, "R3 exclusive fill");
    apply(3'd1, 0, 0, "R8 load hit E");
    apply(3'd5, 0, 0, "R10 store on E");
    apply(3'd4, 0, 0, "R9 evict M");

    apply(3'd2, 1, 0, "R4 prefetch on I");
    apply(3'd2, 1, 0, "R6 prefetch on P");
    apply(3'd4, 1, 0, "R12 evict pending P");
    apply(3'd3, 1, 0, "R5 silent shared fill");
    apply(3'd2, 1, 0, "R6 prefetch on S");
    apply(3'd5, 1, 0, "R10 store on S ignored");
    apply(3'd1, 1, 0, "R8 load hit S");
    apply(3'd4, 1, 0, "R9 evict S clean");

    apply(3'd2, 2, 0, "R4 prefetch line 2");
    apply(3'd1, 2, 0, "R7 load merges prefetch");
    apply(3'd3, 2, 0, "R7 merged fill notifies");

    apply(3'd1, 3, 0, "R2 load miss line 3");
    apply(3'd4, 3, 0, "R12 evict pending IS");
    apply(3'd3, 3, 1, "R3 fill line 3");
    apply(3'd6, 3, 0, "R11 downgrade E");
    apply(3'd6, 3, 0, "R11 downgrade S unchanged");

    apply(3'd1, 7, 0, "R2 load miss last line");
    apply(3'd3, 7, 1, "R3 fill last line");
    apply(3'd5, 7, 0, "R10 store E last line");
    apply(3'd5, 7, 0, "R10 store M stays M");
    apply(3'd6, 7, 0, "R11 downgrade M");
    apply(3'd2, 7, 0, "R6 prefetch on O");
    apply(3'd1, 7, 0, "R8 load hit O");
    apply(3'd3, 7, 1, "R12 fill on stable ignored");
    apply(3'd4, 7, 0, "R9 evict O");

    apply(3'd3, 5, 1, "R12 fill on I ignored");
    apply(3'd4, 5, 0, "R12 evict on I ignored");
    apply(3'd2, 5, 0, "R4 prefetch line 5");
    apply(3'd3, 5, 1, "R5 silent exclusive fill");
    apply(3'd4, 5, 0, "R9 evict E clean");
    apply(3'd0, 5, 0, "R1 idle");

    @(negedge clk);
    op = 3'd0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule